// File: doc/BRIEF.md
# Overflow/Underflow Masked Response Generator

This block sits right after the rounding stage of an extended-precision floating-point datapath. The rounding stage flags an exponent overflow or underflow. This block then builds the result that is written back and the exception requests that go to the status logic. The exponent arrives as a signed, biased value with extra range bits, so it can lie above the largest code or below zero.

When the matching exception is masked, the block substitutes a default result:
- On overflow it returns either infinity or the largest finite value. The choice depends on the rounding mode and the sign. The largest finite value is cut to the selected precision.
- On underflow it flushes very small values to a signed zero and passes everything else through unchanged.

When the exception is unmasked, the block moves the exponent by a fixed rebias amount so that a trap handler can recover the value. The result is registered, so every response appears one clock after its request.

Top module: `omr_top`

## Requirements
- R1: On a masked overflow in round-to-nearest mode (`in_rc`=00), the result is infinity with the input sign. Infinity is exponent 0x7FFF with significand 0x8000_0000_0000_0000. The tag is special (2), and both precision and C1 are requested.
- R2: On a masked overflow in chop mode (`in_rc`=11), the result is the largest finite value with the input sign: exponent 0x7FFE, tag valid (0), precision requested, C1 not requested.
- R3: On a masked overflow in round-down mode (`in_rc`=01), a positive result gives the largest finite value and a negative one gives infinity. In round-up mode (`in_rc`=10) it is the other way round.
- R4: The largest finite significand depends on the precision code `in_pc`. Code 00 (24-bit) gives 0xFFFFFF0000000000. Code 10 (53-bit) gives 0xFFFFFFFFFFFFF800. Codes 11 (64-bit) and 01 (reserved) give all ones.
- R5: On an unmasked overflow, the exponent drops by 24576 while sign and significand stay as they are. The tag is valid, and neither precision nor C1 is requested.
- R6: An overflow event always requests overflow and never requests underflow.
- R7: A masked underflow whose biased exponent is at or below -62 gives a signed zero: exponent 0, significand 0, tag zero (1), C1 0. Both underflow and precision are requested.
- R8: A masked underflow whose biased exponent is above -62 passes the input through with tag valid, and requests underflow and precision.
- R9: On an unmasked underflow, 24576 is added to the exponent, the tag is valid, only underflow is requested, and precision is not.
- R10: A request that carries no event passes the value through with tag valid and with no exception requests.
- R11: Outputs are registered. `out_valid` and the result follow `in_valid` by exactly one clock, and reset clears every output to zero.
- R12: When overflow and underflow are both raised, the overflow response is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| in_sign | input | 1 | Result sign (1 = negative) |
| in_exp | input | EXP_W (18) | Signed biased exponent with extra range |
| in_sig | input | SIG_W (64) | Significand |
| in_rc | input | 2 | Rounding mode: 00 nearest, 01 down, 10 up, 11 chop |
| in_pc | input | 2 | Precision: 00 24-bit, 01 reserved, 10 53-bit, 11 64-bit |
| in_ovf | input | 1 | Overflow event |
| in_unf | input | 1 | Underflow event |
| ovf_mask | input | 1 | Overflow masked when 1 |
| unf_mask | input | 1 | Underflow masked when 1 |
| out_valid | output | 1 | Result strobe |
| out_sign | output | 1 | Result sign |
| out_exp | output | EXP_W (18) | Result exponent |
| out_sig | output | SIG_W (64) | Result significand |
| out_tag | output | 2 | 0 valid, 1 zero, 2 special |
| out_ovf | output | 1 | Overflow request |
| out_unf | output | 1 | Underflow request |
| out_prec | output | 1 | Precision request |
| out_c1 | output | 1 | C1 value (1 = rounded up) |

## Verification
The hardest case to reach is the masked-overflow choice between infinity and the largest finite value. That choice hangs on rounding mode, sign and precision code together, and a sparse directed test would miss most of the combinations. The stimulus therefore sweeps every rounding mode, both signs, every precision code and both mask states. Underflow is driven at exponents on both sides of the flush limit (-62 and -61) and well below it. A cycle with both events raised shows that overflow wins.

// File: rtl/omr_pkg.sv
package omr_pkg;
  typedef enum logic [1:0] {
    TAG_VALID   = 2'd0,
    TAG_ZERO    = 2'd1,
    TAG_SPECIAL = 2'd2
  } tag_e;

  localparam logic [1:0] RC_NEAR = 2'b00;
  localparam logic [1:0] RC_DOWN = 2'b01;
  localparam logic [1:0] RC_UP   = 2'b10;
  localparam logic [1:0] RC_CHOP = 2'b11;

  localparam logic [1:0] PC_SGL = 2'b00;
  localparam logic [1:0] PC_DBL = 2'b10;

  // Masked overflow: 1 when the largest finite value replaces infinity
  function automatic logic want_largest(input logic [1:0] rc, input logic neg);
    case (rc)
      RC_CHOP: want_largest = 1'b1;
      RC_UP:   want_largest = neg;
      RC_DOWN: want_largest = !neg;
      default: want_largest = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/omr_ovf_path.sv
module omr_ovf_path
  import omr_pkg::*;
#(
  parameter int EXP_W  = 18,
  parameter int SIG_W  = 64,
  parameter int FMT_EW = 15,
  parameter int REBIAS = 24576,
  parameter int SGL_P  = 24,
  parameter int DBL_P  = 53
) (
  input  logic                    sign,
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0]        sig_i,
  input  logic [1:0]              rc,
  input  logic [1:0]              pc,
  input  logic                    masked,
  output logic signed [EXP_W-1:0] exp_o,
  output logic [SIG_W-1:0]        sig_o,
  output tag_e                    tag_o,
  output logic                    prec_o,
  output logic                    c1_o,
  output logic                    largest_o
);
  localparam logic signed [EXP_W-1:0] EXP_ALL1 = EXP_W'((1 << FMT_EW) - 1);
  localparam logic signed [EXP_W-1:0] EXP_TOP  = EXP_W'((1 << FMT_EW) - 2);
  localparam logic signed [EXP_W-1:0] REB      = EXP_W'(REBIAS);
  localparam logic [SIG_W-1:0]        INF_SIG  = {1'b1, {(SIG_W-1){1'b0}}};

  function automatic logic [SIG_W-1:0] top_ones(input logic [1:0] p);
    int unsigned bits;
    case (p)
      PC_SGL:  bits = SGL_P;
      PC_DBL:  bits = DBL_P;
      default: bits = SIG_W;
    endcase
    top_ones = {SIG_W{1'b1}} << (SIG_W - bits);
  endfunction

  assign largest_o = masked && want_largest(rc, sign);

  always_comb begin
    exp_o  = exp_i - REB;
    sig_o  = sig_i;
    tag_o  = TAG_VALID;
    prec_o = 1'b0;
    c1_o   = 1'b0;
    if (masked) begin
      prec_o = 1'b1;
      if (largest_o) begin
        exp_o = EXP_TOP;
        sig_o = top_ones(pc);
      end else begin
        exp_o = EXP_ALL1;
        sig_o = INF_SIG;
        tag_o = TAG_SPECIAL;
        c1_o  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/omr_unf_path.sv
module omr_unf_path
  import omr_pkg::*;
#(
  parameter int EXP_W      = 18,
  parameter int SIG_W      = 64,
  parameter int REBIAS     = 24576,
  parameter int MIN_NORM   = 1,
  parameter int FLUSH_SPAN = 63
) (
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0]        sig_i,
  input  logic                    masked,
  output logic signed [EXP_W-1:0] exp_o,
  output logic [SIG_W-1:0]        sig_o,
  output tag_e                    tag_o,
  output logic                    prec_o,
  output logic                    flush_o
);
  localparam logic signed [EXP_W-1:0] REB   = EXP_W'(REBIAS);
  localparam logic signed [EXP_W-1:0] LIMIT = EXP_W'(MIN_NORM - FLUSH_SPAN);

  assign flush_o = masked && (exp_i <= LIMIT);
  assign prec_o  = masked;

  always_comb begin
    exp_o = masked ? exp_i : exp_i + REB;
    sig_o = sig_i;
    tag_o = TAG_VALID;
    if (flush_o) begin
      exp_o = '0;
      sig_o = '0;
      tag_o = TAG_ZERO;
    end
  end
endmodule

// File: rtl/omr_top.sv
module omr_top
  import omr_pkg::*;
#(
  parameter int EXP_W  = 18,
  parameter int SIG_W  = 64,
  parameter int FMT_EW = 15,
  parameter int REBIAS = 24576
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_sign,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [SIG_W-1:0]        in_sig,
  input  logic [1:0]              in_rc,
  input  logic [1:0]              in_pc,
  input  logic                    in_ovf,
  input  logic                    in_unf,
  input  logic                    ovf_mask,
  input  logic                    unf_mask,
  output logic                    out_valid,
  output logic                    out_sign,
  output logic signed [EXP_W-1:0] out_exp,
  output logic [SIG_W-1:0]        out_sig,
  output logic [1:0]              out_tag,
  output logic                    out_ovf,
  output logic                    out_unf,
  output logic                    out_prec,
  output logic                    out_c1
);
  localparam logic signed [EXP_W-1:0] EXP_ALL1 = EXP_W'((1 << FMT_EW) - 1);
  localparam logic signed [EXP_W-1:0] REB      = EXP_W'(REBIAS);

  logic signed [EXP_W-1:0] ov_exp, un_exp, nx_exp;
  logic [SIG_W-1:0]        ov_sig, un_sig, nx_sig;
  tag_e                    ov_tag, un_tag, nx_tag;
  logic                    ov_prec, ov_c1, ov_largest;
  logic                    un_prec, un_flush;
  logic                    ovf_take, unf_take;
  logic                    nx_prec, nx_c1;

  assign ovf_take = in_ovf;
  assign unf_take = in_unf && !in_ovf;   // R12 overflow wins

  omr_ovf_path #(.EXP_W(EXP_W), .SIG_W(SIG_W), .FMT_EW(FMT_EW), .REBIAS(REBIAS)) u_ovf (
    .sign(in_sign), .exp_i(in_exp), .sig_i(in_sig), .rc(in_rc), .pc(in_pc),
    .masked(ovf_mask), .exp_o(ov_exp), .sig_o(ov_sig), .tag_o(ov_tag),
    .prec_o(ov_prec), .c1_o(ov_c1), .largest_o(ov_largest)
  );

  omr_unf_path #(.EXP_W(EXP_W), .SIG_W(SIG_W), .REBIAS(REBIAS)) u_unf (
    .exp_i(in_exp), .sig_i(in_sig), .masked(unf_mask), .exp_o(un_exp),
    .sig_o(un_sig), .tag_o(un_tag), .prec_o(un_prec), .flush_o(un_flush)
  );

  always_comb begin
    nx_exp = in_exp; nx_sig = in_sig; nx_tag = TAG_VALID;
    nx_prec = 1'b0;  nx_c1 = 1'b0;
    if (ovf_take) begin
      nx_exp = ov_exp; nx_sig = ov_sig; nx_tag = ov_tag;
      nx_prec = ov_prec; nx_c1 = ov_c1;
    end else if (unf_take) begin
      nx_exp = un_exp; nx_sig = un_sig; nx_tag = un_tag;
      nx_prec = un_prec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_sign <= 1'b0; out_exp <= '0; out_sig <= '0;
      out_tag <= 2'd0; out_ovf <= 1'b0; out_unf <= 1'b0;
      out_prec <= 1'b0; out_c1 <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sign <= in_sign;
        out_exp  <= nx_exp;
        out_sig  <= nx_sig;
        out_tag  <= nx_tag;
        out_ovf  <= ovf_take;
        out_unf  <= unf_take;
        out_prec <= nx_prec;
        out_c1   <= nx_c1;
      end
    end
  end

  p_inf_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_tag == 2'd2) |->
      (out_exp == EXP_ALL1 && out_sig == {1'b1, {(SIG_W-1){1'b0}}} && out_c1 && out_prec));
  p_largest_no_c1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ovf && ov_largest) |=> (out_tag == 2'd0 && !out_c1 && out_prec));
  p_unmasked_rebias_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ovf && !ovf_mask) |=>
      (out_exp == $past(in_exp) - REB && !out_prec && !out_c1));
  p_ovf_always_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ovf) |=> (out_ovf && !out_unf));
  p_flush_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_tag == 2'd1) |-> (out_sig == '0 && !out_c1 && out_unf && out_prec));
  p_unf_rebias_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && unf_take && !unf_mask) |=> (out_exp == $past(in_exp) + REB && !out_prec));
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ovf && !in_unf) |=> (!out_ovf && !out_unf && !out_prec && !out_c1));
  p_valid_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
endmodule

// File: tb/test_omr_top.sv
module test_omr_top;
  localparam int CLK_PERIOD = 10;
  localparam int EW = 18;
  localparam int SW = 64;

  typedef struct packed {
    logic          sign;
    logic [EW-1:0] exp;
    logic [SW-1:0] sig;
    logic [1:0]    tag;
    logic          ovf, unf, prec, c1;
  } res_t;

  typedef struct packed {
    logic          sign;
    logic [EW-1:0] exp;
    logic [SW-1:0] sig;
    logic          ovf, unf, mask;
  } vec_t;

  // Underflow and no-event vectors near and far from the flush limit
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, -18'sd62,  64'hC000_0000_0000_0001, 1'b0, 1'b1, 1'b1},
    '{1'b1, -18'sd62,  64'h8000_0000_0000_0000, 1'b0, 1'b1, 1'b1},
    '{1'b1, -18'sd61,  64'h0123_4567_89AB_CDEF, 1'b0, 1'b1, 1'b1},
    '{1'b0, -18'sd200, 64'hFFFF_0000_FFFF_0000, 1'b0, 1'b1, 1'b1},
    '{1'b0, 18'sd0,    64'h4000_0000_0000_0000, 1'b0, 1'b1, 1'b1},
    '{1'b0, -18'sd62,  64'hC000_0000_0000_0001, 1'b0, 1'b1, 1'b0},
    '{1'b1, -18'sd200, 64'h8000_0000_0000_0000, 1'b0, 1'b1, 1'b0},
    '{1'b0, 18'sd16383,64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b1},
    '{1'b1, 18'sd5,    64'hDEAD_BEEF_0000_0001, 1'b0, 1'b0, 1'b0},
    '{1'b1, 18'sd1,    64'h8000_0000_0000_0000, 1'b0, 1'b1, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sign = 0, in_ovf = 0, in_unf = 0, ovf_mask = 0, unf_mask = 0;
  logic signed [EW-1:0] in_exp = '0;
  logic [SW-1:0] in_sig = '0;
  logic [1:0] in_rc = 0, in_pc = 0;
  logic out_valid, out_sign, out_ovf, out_unf, out_prec, out_c1;
  logic signed [EW-1:0] out_exp;
  logic [SW-1:0] out_sig;
  logic [1:0] out_tag;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  omr_top i_omr_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign), .in_exp(in_exp),
    .in_sig(in_sig), .in_rc(in_rc), .in_pc(in_pc), .in_ovf(in_ovf), .in_unf(in_unf),
    .ovf_mask(ovf_mask), .unf_mask(unf_mask), .out_valid(out_valid), .out_sign(out_sign),
    .out_exp(out_exp), .out_sig(out_sig), .out_tag(out_tag), .out_ovf(out_ovf),
    .out_unf(out_unf), .out_prec(out_prec), .out_c1(out_c1)
  );

  // Independent reference model written from the requirements
  function automatic res_t model(input logic s, input int e, input logic [SW-1:0] m,
      input logic [1:0] rc, input logic [1:0] pc, input logic ov, input logic un,
      input logic om, input logic um);
    res_t r;
    logic big;
    r = '{sign: s, exp: EW'(e), sig: m, tag: 2'd0, ovf: 1'b0, unf: 1'b0, prec: 1'b0, c1: 1'b0};
    if (ov) begin
      r.ovf = 1'b1;
      if (!om) r.exp = EW'(e - 24576);
      else begin
        r.prec = 1'b1;
        big = (rc == 2'b11) || (rc == 2'b10 && s) || (rc == 2'b01 && !s);
        if (big) begin
          r.exp = 18'h07FFE;
          if (pc == 2'b00)      r.sig = 64'hFFFFFF0000000000;
          else if (pc == 2'b10) r.sig = 64'hFFFFFFFFFFFFF800;
          else                  r.sig = 64'hFFFFFFFFFFFFFFFF;
        end else begin
          r.exp = 18'h07FFF; r.sig = 64'h8000000000000000; r.tag = 2'd2; r.c1 = 1'b1;
        end
      end
    end else if (un) begin
      r.unf = 1'b1;
      if (!um) r.exp = EW'(e + 24576);
      else begin
        r.prec = 1'b1;
        if (e < -61) begin r.exp = '0; r.sig = '0; r.tag = 2'd1; end
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input res_t exp_r);
    res_t act;
    act = '{out_sign, out_exp, out_sig, out_tag, out_ovf, out_unf, out_prec, out_c1};
    n_chk++;
    if (act !== exp_r || out_valid !== 1'b1) begin
      n_fail++;
      $display("FAIL %s: actual %h valid=%b expected %h", req, act, out_valid, exp_r);
    end
  endtask

  task automatic drive(input logic s, input int e, input logic [SW-1:0] m,
      input logic [1:0] rc, input logic [1:0] pc, input logic ov, input logic un,
      input logic om, input logic um, input string req);
    in_valid = 1; in_sign = s; in_exp = EW'(e); in_sig = m; in_rc = rc; in_pc = pc;
    in_ovf = ov; in_unf = un; ovf_mask = om; unf_mask = um;
    @(posedge clk); #1;
    check(req, model(s, e, m, rc, pc, ov, un, om, um));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    n_chk++; // R11 reset state
    if ({out_valid, out_exp, out_sig, out_tag, out_ovf, out_unf, out_prec, out_c1} !== '0) begin
      n_fail++; $display("FAIL R11 reset: actual nonzero expected zero");
    end
    rst_n = 1;
    @(posedge clk); #1;

    // Overflow sweep: R1 R2 R3 R4 R5 R6
    for (int rc = 0; rc < 4; rc++)
      for (int s = 0; s < 2; s++)
        for (int pc = 0; pc < 4; pc++)
          for (int mk = 0; mk < 2; mk++)
            drive(s[0], 32767 + 40 + pc, 64'hA5A5_0000_1234_5678, rc[1:0], pc[1:0],
                  1'b1, 1'b0, mk[0], 1'b0, "R1/R2/R3/R4/R5/R6 overflow sweep");

    // Table walk: R7 R8 R9 R10
    for (int i = 0; i < NV; i++)
      drive(VECS[i].sign, int'($signed(VECS[i].exp)), VECS[i].sig, 2'b00, 2'b11,
            VECS[i].ovf, VECS[i].unf, 1'b1, VECS[i].mask, "R7/R8/R9/R10 table");

    // R12: both events, overflow response wins
    drive(1'b1, 40000, 64'h8000_0000_0000_0000, 2'b11, 2'b10, 1'b1, 1'b1, 1'b1, 1'b1, "R12 both masked");
    drive(1'b0, 40000, 64'h8000_0000_0000_0000, 2'b00, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, "R12 both unmasked");

    // R11: idle cycle drops out_valid after one clock
    in_valid = 0;
    @(posedge clk); #1;
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_fail++; $display("FAIL R11 idle: actual %b expected 0", out_valid);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule